// File: doc/BRIEF.md
# Accumulator ALU with Bit-Manipulation Operations

This block is the arithmetic core of a small accumulator machine. It holds an 8-bit accumulator and computes a new value from it. The computation takes an operation class, a 3-bit operation selector, a second operand and a 3-bit amount or bit position. The result is combinational and appears on its own output while the inputs are held. When the execute enable is high at a rising clock edge, the result is written into the accumulator.

There are four operation classes. The unary class works on the accumulator alone. The register class combines the accumulator with the second operand. The immediate class offers a reduced set of logic operations and a signed add. The compact class does shifts, rotates and single-bit edits at a position given by the amount input. Instruction fetch, decode, branching and memory access are handled elsewhere. The surrounding sequencer drives the class, selector and operands directly.

Top module: `acc_alu8`

## Requirements
- R1: A synchronous active-low reset clears the accumulator to 0x00. Reset takes priority over the execute enable.
- R2: At a rising edge the accumulator takes the value of `result` only when `exec_en` is high. Otherwise it holds its value, whatever the other inputs do.
- R3: `op_class` selects the class: 00 unary, 01 register, 10 immediate, 11 compact. `result` is a combinational function of the accumulator and the current inputs.
- R4: Unary selectors act on the accumulator: 000 gives zero, 001 shift left by one, 010 logical shift right by one, 011 arithmetic shift right by one, 100 increment, 101 decrement, 110 bitwise complement, 111 two's-complement negate. All arithmetic wraps modulo 256.
- R5: Register selectors use `operand` as the second input: 000 add, 001 subtract (accumulator minus operand), 010 and, 011 or, 100 xor, 101 shift left, 110 logical shift right, 111 arithmetic shift right. Shifts move by `operand[2:0]`, and all arithmetic wraps modulo 256.
- R6: In the immediate class, selector 000 is and, 001 is or, 010 is xor and 011 is add, with `operand` read as a signed 8-bit value and the sum wrapped. Selectors 100 to 111 do nothing: `result` equals the accumulator, so executing them leaves the accumulator unchanged.
- R7: Compact selectors 000 to 011 move the accumulator by `amount`: 000 rotate left, 001 shift left, 010 logical shift right, 011 arithmetic shift right. A rotate by 0 returns the value unchanged.
- R8: Compact selector 100 forces bit `amount` to 0, and selector 110 inverts bit `amount`. All other bits are unchanged.
- R9: Compact selector 101 writes `operand[0]` into bit `amount` and keeps all other bits.
- R10: Compact selector 111 returns bit `amount` of the accumulator in bit 0, with bits 7:1 zero.
- R11: Every arithmetic shift right, in any class, fills the vacated upper bits with copies of bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Write `result` into the accumulator at this edge |
| op_class | input | 2 | Operation class selector |
| sub_op | input | 3 | Operation selector within the class |
| operand | input | 8 | Second operand or immediate value |
| amount | input | 3 | Shift or rotate amount, or bit position |
| result | output | 8 | Combinational result of the selected operation |
| acc_q | output | 8 | Current accumulator value |

## Verification
The accumulator is the only state. If it is wrong, the error shows on `acc_q` at once, one edge after the execute pulse that caused it. It also shows on `result` for every later operation, because each operation reads the accumulator. A load at the wrong time is caught by holding `exec_en` low while the inputs change and checking that `acc_q` stays put. A missed load is caught by checking `acc_q` after every pulse. Selector decode faults show on `result` in the same cycle the inputs are applied, so every selector of every class is swept over several accumulator values and bit positions.

// File: rtl/acc_alu_pkg.sv
// Package: shared encodings for the accumulator ALU.
// Assumes 2-bit class and 3-bit selector fields, as the top module drives them.
package acc_alu_pkg;

    typedef enum logic [1:0] {
        CLS_UNARY   = 2'b00,
        CLS_REG     = 2'b01,
        CLS_IMM     = 2'b10,
        CLS_COMPACT = 2'b11
    } op_class_e;

    typedef enum logic [2:0] {
        UN_ZERO = 3'b000,
        UN_SHL1 = 3'b001,
        UN_SHR1 = 3'b010,
        UN_SAR1 = 3'b011,
        UN_INC  = 3'b100,
        UN_DEC  = 3'b101,
        UN_NOT  = 3'b110,
        UN_NEG  = 3'b111
    } unary_op_e;

    typedef enum logic [2:0] {
        BI_ADD = 3'b000,
        BI_SUB = 3'b001,
        BI_AND = 3'b010,
        BI_OR  = 3'b011,
        BI_XOR = 3'b100,
        BI_SHL = 3'b101,
        BI_SHR = 3'b110,
        BI_SAR = 3'b111
    } binary_op_e;

    typedef enum logic [2:0] {
        IM_AND = 3'b000,
        IM_OR  = 3'b001,
        IM_XOR = 3'b010,
        IM_ADD = 3'b011
    } imm_op_e;

    typedef enum logic [2:0] {
        CP_ROL = 3'b000,
        CP_SHL = 3'b001,
        CP_SHR = 3'b010,
        CP_SAR = 3'b011,
        CP_CLR = 3'b100,
        CP_INS = 3'b101,
        CP_TOG = 3'b110,
        CP_EXT = 3'b111
    } compact_op_e;

endpackage

// File: rtl/alu_unary_unit.sv
// Module: alu_unary_unit
// Computes the single-operand operations on the accumulator.
// Assumes W >= 2. Arithmetic wraps modulo 2**W.
module alu_unary_unit
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [2:0]   code,
    output logic [W-1:0] y
);

    // Select the unary operation.
    always_comb begin
        unique case (code)
            UN_ZERO: y = '0;
            UN_SHL1: y = {a[W-2:0], 1'b0};
            UN_SHR1: y = {1'b0, a[W-1:1]};
            UN_SAR1: y = {a[W-1], a[W-1:1]};
            UN_INC:  y = a + W'(1);
            UN_DEC:  y = a - W'(1);
            UN_NOT:  y = ~a;
            default: y = W'(0) - a;
        endcase
    end

endmodule

// File: rtl/alu_binary_unit.sv
// Module: alu_binary_unit
// Computes the two-operand operations. The immediate class reuses it.
// Assumes W is a power of two. Shifts use the low log2(W) bits of b.
module alu_binary_unit
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   code,
    output logic [W-1:0] y
);

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] sh;

    // Take the shift distance from the operand's low bits.
    always_comb sh = b[SHW-1:0];

    // Select the binary operation.
    always_comb begin
        unique case (code)
            BI_ADD:  y = a + b;
            BI_SUB:  y = a - b;
            BI_AND:  y = a & b;
            BI_OR:   y = a | b;
            BI_XOR:  y = a ^ b;
            BI_SHL:  y = a << sh;
            BI_SHR:  y = a >> sh;
            default: y = W'($signed(a) >>> sh);
        endcase
    end

endmodule

// File: rtl/alu_compact_unit.sv
// Module: alu_compact_unit
// Computes rotates, shifts and single-bit edits at a bit position.
// Assumes W is a power of two, so every value of pos names a valid bit.
module alu_compact_unit
    import acc_alu_pkg::*;
#(
    parameter int W = 8,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic           ins_bit,
    input  logic [2:0]     code,
    input  logic [SHW-1:0] pos,
    output logic [W-1:0]   y
);

    logic [2*W-1:0] dbl;
    logic [W-1:0]   mask;

    // Build the rotate window from two copies of the value.
    always_comb dbl = {a, a} << pos;

    // Build a one-hot mask for the addressed bit.
    always_comb mask = W'(1) << pos;

    // Select the compact operation.
    always_comb begin
        unique case (code)
            CP_ROL:  y = dbl[2*W-1:W];
            CP_SHL:  y = a << pos;
            CP_SHR:  y = a >> pos;
            CP_SAR:  y = W'($signed(a) >>> pos);
            CP_CLR:  y = a & ~mask;
            CP_INS:  y = (a & ~mask) | (ins_bit ? mask : '0);
            CP_TOG:  y = a ^ mask;
            default: y = {{(W-1){1'b0}}, a[pos]};
        endcase
    end

endmodule

// File: rtl/acc_alu8.sv
// Module: acc_alu8 (top)
// Holds the accumulator and routes it through the unit chosen by the class.
// Assumes the sequencer keeps the inputs stable around the enabled edge.
module acc_alu8
    import acc_alu_pkg::*;
#(
    parameter int W = 8,
    localparam int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exec_en,
    input  logic [1:0]     op_class,
    input  logic [2:0]     sub_op,
    input  logic [W-1:0]   operand,
    input  logic [SHW-1:0] amount,
    output logic [W-1:0]   result,
    output logic [W-1:0]   acc_q
);

    logic [W-1:0] un_y, rg_y, im_y, cp_y;
    logic [2:0]   imm_code;
    logic         imm_valid;

    // Map the immediate selector onto the shared binary unit's codes.
    always_comb begin
        imm_valid = 1'b1;
        unique case (sub_op)
            IM_AND:  imm_code = BI_AND;
            IM_OR:   imm_code = BI_OR;
            IM_XOR:  imm_code = BI_XOR;
            IM_ADD:  imm_code = BI_ADD;
            default: begin
                imm_code  = BI_ADD;
                imm_valid = 1'b0;
            end
        endcase
    end

    alu_unary_unit #(.W(W)) u_unary (
        .a    (acc_q),
        .code (sub_op),
        .y    (un_y)
    );

    alu_binary_unit #(.W(W)) u_reg (
        .a    (acc_q),
        .b    (operand),
        .code (sub_op),
        .y    (rg_y)
    );

    alu_binary_unit #(.W(W)) u_imm (
        .a    (acc_q),
        .b    (operand),
        .code (imm_code),
        .y    (im_y)
    );

    alu_compact_unit #(.W(W)) u_compact (
        .a       (acc_q),
        .ins_bit (operand[0]),
        .code    (sub_op),
        .pos     (amount),
        .y       (cp_y)
    );

    // Pick the result of the selected class.
    always_comb begin
        unique case (op_class)
            CLS_UNARY: result = un_y;
            CLS_REG:   result = rg_y;
            CLS_IMM:   result = imm_valid ? im_y : acc_q;
            default:   result = cp_y;
        endcase
    end

    // Accumulator register: reset to zero, load only on enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (exec_en)
            acc_q <= result;
    end

endmodule

// File: rtl/acc_alu8_checker.sv
// Module: acc_alu8_checker
// Clocked properties that relate the top module's ports over time.
// It is attached to every acc_alu8 instance by the bind below.
module acc_alu8_checker #(
    parameter int W = 8,
    localparam int SHW = $clog2(W)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           exec_en,
    input logic [1:0]     op_class,
    input logic [2:0]     sub_op,
    input logic [W-1:0]   operand,
    input logic [SHW-1:0] amount,
    input logic [W-1:0]   result,
    input logic [W-1:0]   acc_q
);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> $stable(acc_q));

    assert_load_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> acc_q == $past(result));

    assert_imm_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b10 && sub_op[2]) |-> result == acc_q);

    assert_rotate_weight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11 && sub_op == 3'b000) |-> $countones(result) == $countones(acc_q));

    assert_clear_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11 && sub_op == 3'b100) |-> !result[amount]);

    assert_toggle_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11 && sub_op == 3'b110) |-> $countones(result ^ acc_q) == 1);

    assert_insert_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11 && sub_op == 3'b101) |-> result[amount] == operand[0]);

    assert_extract_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b11 && sub_op == 3'b111) |-> result[W-1:1] == '0);

    assert_sar_sign_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == 2'b00 && sub_op == 3'b011) |-> result[W-1] == acc_q[W-1]);

endmodule

bind acc_alu8 acc_alu8_checker #(.W(W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_en  (exec_en),
    .op_class (op_class),
    .sub_op   (sub_op),
    .operand  (operand),
    .amount   (amount),
    .result   (result),
    .acc_q    (acc_q)
);

// File: tb/acc_alu8_test.sv
// Directed bench for acc_alu8. Each scenario task checks its own results
// against a model written from the requirements.
module acc_alu8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [1:0] op_class = 2'b00;
    logic [2:0] sub_op = 3'b000;
    logic [7:0] operand = 8'h00;
    logic [2:0] amount = 3'b000;
    logic [7:0] result;
    logic [7:0] acc_q;

    int vectors = 0;
    int fails = 0;
    logic [7:0] acc_m = 8'h00;

    acc_alu8 uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_en  (exec_en),
        .op_class (op_class),
        .sub_op   (sub_op),
        .operand  (operand),
        .amount   (amount),
        .result   (result),
        .acc_q    (acc_q)
    );

    always #5 clk = ~clk;

    // Model of the result, written from the requirements.
    function automatic logic [7:0] model(input logic [1:0] c, input logic [2:0] s,
                                         input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] n);
        logic [7:0] r;
        int k;
        r = a;
        case (c)
            2'b00: case (s)  // R4
                3'd0: r = 8'h00;
                3'd1: r = 8'((int'(a) * 2) % 256);
                3'd2: r = 8'(int'(a) / 2);
                3'd3: r = {a[7], a[7:1]};
                3'd4: r = 8'((int'(a) + 1) % 256);
                3'd5: r = 8'((int'(a) + 255) % 256);
                3'd6: r = 8'hFF - a;
                3'd7: r = 8'((256 - int'(a)) % 256);
            endcase
            2'b01: begin  // R5
                k = int'(b[2:0]);
                case (s)
                    3'd0: r = 8'((int'(a) + int'(b)) % 256);
                    3'd1: r = 8'((int'(a) + 256 - int'(b)) % 256);
                    3'd2: r = a & b;
                    3'd3: r = a | b;
                    3'd4: r = a ^ b;
                    3'd5: begin r = a; for (int i = 0; i < k; i++) r = {r[6:0], 1'b0}; end
                    3'd6: begin r = a; for (int i = 0; i < k; i++) r = {1'b0, r[7:1]}; end
                    3'd7: begin r = a; for (int i = 0; i < k; i++) r = {r[7], r[7:1]}; end
                endcase
            end
            2'b10: case (s)  // R6
                3'd0: r = a & b;
                3'd1: r = a | b;
                3'd2: r = a ^ b;
                3'd3: r = 8'((int'(a) + int'($signed(b)) + 256) % 256);
                default: r = a;
            endcase
            2'b11: begin  // R7..R10
                k = int'(n);
                case (s)
                    3'd0: begin r = a; for (int i = 0; i < k; i++) r = {r[6:0], r[7]}; end
                    3'd1: begin r = a; for (int i = 0; i < k; i++) r = {r[6:0], 1'b0}; end
                    3'd2: begin r = a; for (int i = 0; i < k; i++) r = {1'b0, r[7:1]}; end
                    3'd3: begin r = a; for (int i = 0; i < k; i++) r = {r[7], r[7:1]}; end
                    3'd4: begin r = a; r[k] = 1'b0; end
                    3'd5: begin r = a; r[k] = b[0]; end
                    3'd6: begin r = a; r[k] = ~a[k]; end
                    3'd7: r = {7'b0, a[k]};
                endcase
            end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one operation with enable, check result, then the loaded accumulator.
    task automatic apply(input logic [1:0] c, input logic [2:0] s, input logic [7:0] b,
                         input logic [2:0] n, input string req);
        logic [7:0] exp;
        @(negedge clk);
        op_class = c; sub_op = s; operand = b; amount = n; exec_en = 1'b1;
        #1;
        exp = model(c, s, acc_m, b, n);
        check(req, result, exp);
        @(negedge clk);
        exec_en = 1'b0;
        acc_m = exp;
        check("R2", acc_q, acc_m);
    endtask

    task automatic set_acc(input logic [7:0] v);
        apply(2'b00, 3'd0, 8'h00, 3'd0, "R4");
        apply(2'b10, 3'd1, v, 3'd0, "R6");
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", acc_q, 8'h00);
        rst_n = 1'b1;
        acc_m = 8'h00;
    endtask

    task automatic t_unary;
        logic [7:0] seeds [4] = '{8'h00, 8'h81, 8'h7F, 8'hFF};
        foreach (seeds[j])
            for (int s = 0; s < 8; s++) begin
                set_acc(seeds[j]);
                apply(2'b00, 3'(s), 8'h5A, 3'd0, (s == 3) ? "R11" : "R4");
            end
    endtask

    task automatic t_register;
        logic [7:0] av [3] = '{8'hC3, 8'h10, 8'hF0};
        logic [7:0] bv [3] = '{8'h45, 8'hF3, 8'h0B};
        for (int j = 0; j < 3; j++)
            for (int s = 0; s < 8; s++) begin
                set_acc(av[j]);
                apply(2'b01, 3'(s), bv[j], 3'd0, (s == 7) ? "R11" : "R5");
            end
    endtask

    task automatic t_immediate;
        for (int s = 0; s < 8; s++) begin
            set_acc(8'h9C);
            apply(2'b10, 3'(s), 8'hF6, 3'd5, "R6");
        end
        set_acc(8'hFE);
        apply(2'b10, 3'd3, 8'h05, 3'd0, "R6");
        apply(2'b10, 3'd3, 8'h80, 3'd0, "R6");
    endtask

    task automatic t_compact;
        for (int s = 0; s < 8; s++)
            for (int n = 0; n < 8; n++) begin
                string tag;
                case (s)
                    0, 1, 2: tag = "R7";
                    3: tag = "R11";
                    4, 6: tag = "R8";
                    5: tag = "R9";
                    default: tag = "R10";
                endcase
                set_acc(8'hB5);
                apply(2'b11, 3'(s), (n % 2 == 0) ? 8'h01 : 8'hFE, 3'(n), tag);
            end
        set_acc(8'h6D);
        apply(2'b11, 3'd0, 8'h00, 3'd0, "R7");
        check("R7", acc_q, 8'h6D);
    endtask

    task automatic t_hold;
        set_acc(8'h3C);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            op_class = 2'(i); sub_op = 3'(i + 3); operand = 8'(i * 37); amount = 3'(i);
            exec_en = 1'b0;
            #1;
            check("R3", result, model(op_class, sub_op, acc_m, operand, amount));
            @(negedge clk);
            check("R2", acc_q, 8'h3C);
        end
    endtask

    task automatic t_reset_priority;
        set_acc(8'hA7);
        @(negedge clk);
        rst_n = 1'b0; exec_en = 1'b1; op_class = 2'b00; sub_op = 3'd6;
        @(negedge clk);
        check("R1", acc_q, 8'h00);
        rst_n = 1'b1; exec_en = 1'b0;
        acc_m = 8'h00;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_unary();
        t_register();
        t_immediate();
        t_compact();
        t_hold();
        t_reset_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule